// File: doc/BRIEF.md
# Function Configuration Register Space

This block is the register target for one function's configuration space. The space holds 4096 byte-addressed registers and is reached one dword at a time through a request port. Each request carries a byte offset, per-byte write enables, a read/write flag and write data. A read returns its dword one cycle later on a response port. The first dword holds fixed vendor and device identity values. The rest of the 64-byte header reads as zero. The vendor region above the header is writable scratch storage, and a parameterised block of scratch dwords sits at the start of the extended space above offset 0xFF.

The last two dwords of the low 256 bytes form an indirect pair, so software that can only reach the low 256 bytes can still reach the whole space. Offset 0xF8 holds a dword-aligned pointer. Offset 0xFC is a window onto whichever dword that pointer selects. The window can reach the extended space and the low space alike. When the pointer selects the pair itself, the window reads as zero and discards writes, so an access can never loop back on itself.

Top module: `cfg_space_target`

## Requirements
- R1: After reset, every writable scratch dword and the pointer at 0xF8 read as zero, and `rsp_valid` is low.
- R2: A read of offset 0x000 returns the vendor ID in bits 15:0 and the device ID in bits 31:16. The low-address byte sits in the least significant bits.
- R3: Writes to the identity dword at 0x000 have no effect, whatever the byte enables.
- R4: Header dwords 0x004 to 0x03C read as zero and ignore writes.
- R5: Dwords 0x040 to 0x0F4 are writable storage. Write-enable bit i controls data bits 8i+7:8i, and a disabled byte keeps its old value.
- R6: `rsp_valid` goes high for exactly the one cycle that follows a read request, and it stays low after a write. `rsp_rdata` then holds the dword as it was when the read was presented.
- R7: A write to 0xF8 merges the enabled bytes into the pointer and keeps only bits 11:2, which gives a value from 0x000 to 0xFFC. A read of 0xF8 returns that value, with all other bits zero.
- R8: A read or write at 0xFC acts on the dword the pointer selects, with the same effect a direct access to that offset would have.
- R9: While the pointer holds 0xF8 or 0xFC, reads at 0xFC return zero and writes at 0xFC change nothing, including the pointer itself.
- R10: Extended dwords from 0x100 up to 0x100 + 4·EXT_DWORDS − 4 are writable storage that can be reached directly. Higher extended offsets read as zero and ignore writes.
- R11: Address bits 1:0 are ignored. Every access acts on the aligned dword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset into the 4 KB space |
| req_be | input | 4 | Per-byte write enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench checks partial byte-enable merges into both scratch storage and the pointer. A design that writes whole dwords would corrupt the unselected bytes. It drives an all-ones write to 0xF8, which catches a pointer that keeps its low two bits or the bits above 11, and it walks the window through the extended storage, the identity dword and the low scratch region, which exposes any target decode that ignores the pointer. It aims the window at the pair itself, where a design without the recursion guard would return the pointer or overwrite it. It also probes the first dword past the implemented extended storage, where an off-by-one bound would alias onto a real register.

// File: rtl/cfg_space_target.sv
module cfg_space_target #(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
  parameter int          EXT_DWORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);

  localparam int          LOW_FIRST = 16;
  localparam int          LOW_COUNT = 46;
  localparam logic [9:0]  IDX_DW    = 10'd62;
  localparam logic [9:0]  WIN_DW    = 10'd63;
  localparam int          EXT_FIRST = 64;
  localparam int          SLOTS     = LOW_COUNT + EXT_DWORDS;
  localparam int          SW        = $clog2(SLOTS);
  localparam logic [10:0] EXT_END   = 11'(EXT_FIRST + EXT_DWORDS);

  logic [9:0]  idx_q;
  logic [31:0] mem [SLOTS];

  wire [9:0] dir_dw      = req_addr[11:2];
  wire       via_win     = (dir_dw == WIN_DW);
  wire [9:0] tgt_dw      = via_win ? idx_q : dir_dw;
  wire       tgt_blocked = via_win && (idx_q == IDX_DW || idx_q == WIN_DW);
  wire       rd_req      = req_valid && !req_write;
  wire       wr_req      = req_valid && req_write && !tgt_blocked;

  wire hit_low = (tgt_dw >= 10'(LOW_FIRST)) && (tgt_dw < IDX_DW);
  wire hit_ext = ({1'b0, tgt_dw} >= 11'(EXT_FIRST)) && ({1'b0, tgt_dw} < EXT_END);

  wire [9:0]    slot_full = hit_low ? (tgt_dw - 10'(LOW_FIRST))
                                    : (tgt_dw - 10'(EXT_FIRST) + 10'(LOW_COUNT));
  wire [SW-1:0] slot      = slot_full[SW-1:0];

  function automatic logic [31:0] merge(input logic [31:0] old_w,
                                        input logic [31:0] new_w,
                                        input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return r;
  endfunction

  wire [31:0] idx_word   = {20'b0, idx_q, 2'b00};
  wire [31:0] idx_merged = merge(idx_word, req_wdata, req_be);

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (tgt_blocked)                   rd_word = '0;
    else if (tgt_dw == 10'd0)          rd_word = {DEVICE_ID, VENDOR_ID};
    else if (tgt_dw == IDX_DW)         rd_word = idx_word;
    else if (hit_low || hit_ext)       rd_word = mem[slot];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else if (wr_req) begin
      if (tgt_dw == IDX_DW)            idx_q     <= idx_merged[11:2];
      else if (hit_low || hit_ext)     mem[slot] <= merge(mem[slot], req_wdata, req_be);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_word;
    end
  end

  a_r6_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  a_r6_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);

  a_r2_identity_dword: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !tgt_blocked && tgt_dw == 10'd0) |=> (rsp_rdata == {DEVICE_ID, VENDOR_ID}));

  a_r9_window_self_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && tgt_blocked) |=> (rsp_rdata == 32'd0));

  a_r9_pointer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && tgt_blocked) |=> $stable(idx_q));

  a_r7_pointer_form: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && dir_dw == IDX_DW) |=> (rsp_rdata[1:0] == 2'b00 && rsp_rdata[31:12] == 20'd0));

  a_r4_header_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !tgt_blocked && tgt_dw != 10'd0 && tgt_dw < 10'(LOW_FIRST)) |=> (rsp_rdata == 32'd0));

endmodule

// File: tb/cfg_space_target_test.sv
module cfg_space_target_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  always #5 clk = ~clk;

  cfg_space_target uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 4'h0, 32'h0,        32'h3C4D1A2B, 4'd2},  // R2
    '{1'b1, 12'h000, 4'hF, 32'hFFFFFFFF, 32'h0,        4'd3},
    '{1'b0, 12'h000, 4'h0, 32'h0,        32'h3C4D1A2B, 4'd3},  // R3
    '{1'b1, 12'h010, 4'hF, 32'h12345678, 32'h0,        4'd4},
    '{1'b0, 12'h010, 4'h0, 32'h0,        32'h00000000, 4'd4},  // R4
    '{1'b1, 12'h040, 4'hF, 32'hA5A5A5A5, 32'h0,        4'd5},
    '{1'b0, 12'h040, 4'h0, 32'h0,        32'hA5A5A5A5, 4'd5},  // R5
    '{1'b1, 12'h040, 4'h5, 32'h11223344, 32'h0,        4'd5},
    '{1'b0, 12'h040, 4'h0, 32'h0,        32'hA522A544, 4'd5},  // R5 partial
    '{1'b1, 12'h0F4, 4'hF, 32'hDEADBEEF, 32'h0,        4'd5},
    '{1'b0, 12'h0F6, 4'h0, 32'h0,        32'hDEADBEEF, 4'd11}, // R11
    '{1'b1, 12'h0F8, 4'hF, 32'hFFFFFFFF, 32'h0,        4'd7},
    '{1'b0, 12'h0F8, 4'h0, 32'h0,        32'h00000FFC, 4'd7},  // R7 mask
    '{1'b1, 12'h0F8, 4'hF, 32'h00000103, 32'h0,        4'd7},
    '{1'b0, 12'h0F8, 4'h0, 32'h0,        32'h00000100, 4'd7},  // R7
    '{1'b1, 12'h0FC, 4'hF, 32'hCAFEF00D, 32'h0,        4'd8},
    '{1'b0, 12'h100, 4'h0, 32'h0,        32'hCAFEF00D, 4'd8},  // R8 window write
    '{1'b1, 12'h104, 4'hF, 32'h0BADC0DE, 32'h0,        4'd10},
    '{1'b1, 12'h0F8, 4'hF, 32'h00000104, 32'h0,        4'd8},
    '{1'b0, 12'h0FC, 4'h0, 32'h0,        32'h0BADC0DE, 4'd8},  // R8 window read
    '{1'b1, 12'h0F8, 4'hF, 32'h00000000, 32'h0,        4'd8},
    '{1'b0, 12'h0FC, 4'h0, 32'h0,        32'h3C4D1A2B, 4'd8},  // R8 to id
    '{1'b1, 12'h0F8, 4'hF, 32'h00000040, 32'h0,        4'd8},
    '{1'b0, 12'h0FC, 4'h0, 32'h0,        32'hA522A544, 4'd8},  // R8 to low
    '{1'b1, 12'h0F8, 4'hF, 32'h000000F8, 32'h0,        4'd9},
    '{1'b1, 12'h0FC, 4'hF, 32'h55555555, 32'h0,        4'd9},
    '{1'b0, 12'h0FC, 4'h0, 32'h0,        32'h00000000, 4'd9},  // R9
    '{1'b0, 12'h0F8, 4'h0, 32'h0,        32'h000000F8, 4'd9},  // R9 pointer kept
    '{1'b1, 12'h0F8, 4'hF, 32'h000000FC, 32'h0,        4'd9},
    '{1'b0, 12'h0FC, 4'h0, 32'h0,        32'h00000000, 4'd9},  // R9
    '{1'b1, 12'h200, 4'hF, 32'h77777777, 32'h0,        4'd10},
    '{1'b0, 12'h200, 4'h0, 32'h0,        32'h00000000, 4'd10}, // R10 beyond
    '{1'b1, 12'h1FC, 4'h8, 32'hAB000000, 32'h0,        4'd10},
    '{1'b0, 12'h1FC, 4'h0, 32'h0,        32'hAB000000, 4'd10}, // R10 last
    '{1'b1, 12'h0F8, 4'h1, 32'h00000044, 32'h0,        4'd7},
    '{1'b0, 12'h0F8, 4'h0, 32'h0,        32'h00000044, 4'd7}   // R7 byte merge
  };

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, output logic vld, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    vld = rsp_valid;
    rd  = rsp_rdata;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic        v;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    access(1'b0, 12'h080, 4'h0, 32'h0, v, d);
    check("R1 scratch zero", d, 32'd0);
    access(1'b0, 12'h0F8, 4'h0, 32'h0, v, d);
    check("R1 pointer zero", d, 32'd0);
    access(1'b0, 12'h180, 4'h0, 32'h0, v, d);
    check("R1 ext zero", d, 32'd0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wdata, v, d);
      if (!VECS[i].wr)
        check($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
    end

    // R6: write gives no response, read gives exactly one
    access(1'b1, 12'h080, 4'hF, 32'h0F0F0F0F, v, d);
    check("R6 no rsp after write", {31'b0, v}, 32'd0);
    access(1'b0, 12'h080, 4'h0, 32'h0, v, d);
    check("R6 rsp after read", {31'b0, v}, 32'd1);
    check("R6 read data", d, 32'h0F0F0F0F);
    @(negedge clk);
    check("R6 single cycle", {31'b0, rsp_valid}, 32'd0);

    // R1: reset clears storage again
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 12'h080, 4'h0, 32'h0, v, d);
    check("R1 scratch cleared", d, 32'd0);
    access(1'b0, 12'h100, 4'h0, 32'h0, v, d);
    check("R1 ext cleared", d, 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule